// File: doc/BRIEF.md
# Cache Tag Store with Equality Compare

This block keeps one tag word per cache set and tells, within the same cycle, whether the tag held at the presented address equals the tag presented on the data input. A cache controller drives the set index on the address port and the upper address bits of the request on the data input. It reads the active-high hit flag before the next clock edge. Writes load a new tag on a refill. A single clear pulse invalidates the whole directory at once, for example on a cache flush.

The design is built from slices of `SLICE_W` bits each. `SLICES` slices side by side form a wider tag, and their per-slice equality results are combined by logical AND, so a hit needs every slice to agree. The data bus is split into an input, an output and an output-enable flag that stands in for the tri-state driver. A per-entry valid bit makes the clear take one cycle. An entry that is not valid behaves as if it held zero.

Top module: `tag_cmp_array`

## Requirements
- R1: After reset every entry reads as zero, and comparing the value zero at any address gives a hit.
- R2: With `we` high and `clr` low at a rising clock edge, `din` is stored at `addr` and is returned by later reads of that address.
- R3: `data_oe` equals `oe` in the same cycle. While `oe` is high, `dout` carries the word stored at `addr`. While `oe` is low, `dout` is zero.
- R4: With `we`, `clr` and `oe` all low, `match` is high in the same cycle when the stored word at `addr` equals `din`.
- R5: Under the same conditions, `match` is low when any bit of the stored word differs from `din`.
- R6: `match` is the AND of the slice results: slice k covers bits [k*SLICE_W +: SLICE_W], and a mismatch confined to a single slice drops `match`.
- R7: `clr` high at a rising clock edge invalidates every entry, so afterwards every address reads and compares as zero.
- R8: `match` is low in any cycle where `we`, `clr` or `oe` is high.
- R9: When `clr` and `we` are both high at an edge, the clear takes effect and the write is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and clears take effect on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, invalidates all entries |
| addr | input | ADDR_W | Entry select |
| din | input | SLICES*SLICE_W | Write data and compare operand |
| dout | output | SLICES*SLICE_W | Read data, zero when not enabled |
| data_oe | output | 1 | High when `dout` is being driven onto the bus |
| we | input | 1 | Write enable |
| oe | input | 1 | Output enable |
| clr | input | 1 | Invalidate the whole array |
| match | output | 1 | Active-high hit, AND of all slices |

## Verification
The compare is tried with an exact copy of a stored tag, which must give a hit. It is also tried with an operand that differs only in the low slice and with one that differs only in the high slice, which shows that the per-slice results are ANDed and not ORed or truncated. Comparing zero against entries that were never written, and against entries that were written and then cleared, separates an invalid entry from a stored zero. Compares during reads, writes and clears confirm the forced miss. A random run against an associative-array model then mixes writes, reads, compares, clears and clear-with-write over a small set of addresses that includes the top one.

// File: rtl/tag_cmp_array.sv
module tag_cmp_array #(
  parameter int ADDR_W  = 12,
  parameter int SLICE_W = 4,
  parameter int SLICES  = 1,
  localparam int DEPTH  = 1 << ADDR_W,
  localparam int W      = SLICE_W * SLICES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      din,
  output logic [W-1:0]      dout,
  output logic              data_oe,
  input  logic              we,
  input  logic              oe,
  input  logic              clr,
  output logic              match
);

  logic [W-1:0]      mem [DEPTH];
  logic [DEPTH-1:0]  valid;
  logic [W-1:0]      stored;
  logic [SLICES-1:0] slice_hit;
  logic              cmp_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     valid <= '0;
    else if (clr)   valid <= '0;
    else if (we)    valid[addr] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (we && !clr) mem[addr] <= din;
  end

  assign stored = valid[addr] ? mem[addr] : '0;

  for (genvar g = 0; g < SLICES; g++) begin : g_slice
    assign slice_hit[g] = (stored[g*SLICE_W +: SLICE_W] == din[g*SLICE_W +: SLICE_W]);
  end

  assign cmp_en  = !(we || clr || oe);
  assign match   = cmp_en && (&slice_hit);
  assign data_oe = oe;
  assign dout    = oe ? stored : '0;

  // R7: one clear pulse empties every entry
  a_r7_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (dout == '0));

  // R9: a write in the same cycle as a clear leaves nothing behind
  a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && we) |=> (dout == '0));

  // R2: a written word reads back on the next cycle at the same address
  a_r2_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !clr) |=> (!(oe && addr == $past(addr)) || dout == $past(din)));

  // R4: with nothing changing, the compare result holds steady
  a_r4_hit_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_en && $past(cmp_en) && $stable(addr) && $stable(din)) |-> $stable(match));

  // R4: a compare agrees with the word read just before it
  a_r4_match_consistent: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(oe) && !$past(we) && !$past(clr) && cmp_en && addr == $past(addr))
      |-> (match == (din == $past(dout))));

  // R8: no hit while the bus is busy with another operation
  a_r8_forced_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we || clr || oe) |-> !match);

endmodule

// File: tb/tag_cmp_array_test.sv
module tag_cmp_array_test;
  localparam int AW = 12;
  localparam int SW = 4;
  localparam int NS = 2;
  localparam int DW = SW * NS;

  localparam int OP_W = 0, OP_C = 1, OP_R = 2, OP_CLR = 3, OP_WC = 4;

  typedef struct packed {
    logic [2:0]    op;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    logic          m;
    logic [DW-1:0] q;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VT [NV] = '{
    '{3'(OP_W),   12'h005, 8'hA3, 1'b0, 8'h00},
    '{3'(OP_C),   12'h005, 8'hA3, 1'b1, 8'h00},
    '{3'(OP_C),   12'h005, 8'hA2, 1'b0, 8'h00},
    '{3'(OP_C),   12'h005, 8'hB3, 1'b0, 8'h00},
    '{3'(OP_R),   12'h005, 8'h00, 1'b0, 8'hA3},
    '{3'(OP_W),   12'hFFF, 8'h5C, 1'b0, 8'h00},
    '{3'(OP_R),   12'hFFF, 8'h00, 1'b0, 8'h5C},
    '{3'(OP_C),   12'h006, 8'h00, 1'b1, 8'h00},
    '{3'(OP_C),   12'hFFF, 8'h5C, 1'b1, 8'h00},
    '{3'(OP_CLR), 12'h000, 8'h00, 1'b0, 8'h00},
    '{3'(OP_R),   12'h005, 8'h00, 1'b0, 8'h00},
    '{3'(OP_R),   12'hFFF, 8'h00, 1'b0, 8'h00},
    '{3'(OP_C),   12'h005, 8'hA3, 1'b0, 8'h00},
    '{3'(OP_W),   12'h010, 8'h77, 1'b0, 8'h00},
    '{3'(OP_WC),  12'h010, 8'h11, 1'b0, 8'h00},
    '{3'(OP_R),   12'h010, 8'h00, 1'b0, 8'h00}
  };

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0, dout;
  logic data_oe, we = 0, oe = 0, clr = 0, match;
  int n_run = 0, n_fail = 0;
  logic [DW-1:0] model [int];

  always #2.5 clk = ~clk;

  tag_cmp_array #(.ADDR_W(AW), .SLICE_W(SW), .SLICES(NS)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .dout(dout),
    .data_oe(data_oe), .we(we), .oe(oe), .clr(clr), .match(match));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input int op, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    addr = a; din = d;
    we  = (op == OP_W || op == OP_WC);
    clr = (op == OP_CLR || op == OP_WC);
    oe  = (op == OP_R);
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    we = 0; clr = 0; oe = 0; din = '0;
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    drive(OP_R, 12'h000, '0);
    chk("R1 read after reset", 32'(dout), 0);
    chk("R3 data_oe with oe", 32'(data_oe), 1);
    drive(OP_C, 12'h7A3, '0);
    chk("R1 zero compare after reset", 32'(match), 1);
    chk("R3 dout idle", 32'(dout), 0);
    chk("R3 data_oe idle", 32'(data_oe), 0);

    for (int i = 0; i < NV; i++) begin
      drive(int'(VT[i].op), VT[i].a, VT[i].d);
      if (VT[i].op == 3'(OP_C))
        chk(VT[i].m ? "R4 table hit" : "R5 R6 R7 table miss", 32'(match), 32'(VT[i].m));
      else
        chk("R8 table forced miss", 32'(match), 0);
      if (VT[i].op == 3'(OP_R))
        chk("R2 R7 R9 table read", 32'(dout), 32'(VT[i].q));
      else
        chk("R3 table bus idle", 32'(dout), 0);
    end

    drive(OP_W, 12'h020, 8'h3C);
    drive(OP_R, 12'h020, 8'h3C);
    chk("R8 miss during read", 32'(match), 0);
    drive(OP_W, 12'h020, 8'h3C);
    chk("R8 miss during write", 32'(match), 0);
    drive(OP_CLR, 12'h020, 8'h3C);
    chk("R8 miss during clear", 32'(match), 0);
    drive(OP_C, 12'h020, 8'h00);
    chk("R7 cleared entry compares zero", 32'(match), 1);

    idle();
    model.delete();
    for (int i = 0; i < 1500; i++) begin
      int op;
      logic [AW-1:0] a;
      logic [DW-1:0] d, e;
      op = int'($urandom_range(0, 19));
      op = (op < 6) ? OP_W : (op < 12) ? OP_C : (op < 17) ? OP_R : (op < 18) ? OP_WC : OP_CLR;
      a  = ($urandom_range(0, 8) == 8) ? 12'hFFF : AW'($urandom_range(0, 7));
      e  = model.exists(int'(a)) ? model[int'(a)] : '0;
      case ($urandom_range(0, 3))
        0: d = e;
        1: d = e ^ DW'(1 << $urandom_range(0, DW - 1));
        default: d = DW'($urandom);
      endcase
      drive(op, a, d);
      if (op == OP_C) chk((d == e) ? "R4 random hit" : "R5 R6 random miss", 32'(match), 32'(d == e));
      else            chk("R8 random forced miss", 32'(match), 0);
      if (op == OP_R) chk("R2 R7 random read", 32'(dout), 32'(e));
      if (op == OP_W) model[int'(a)] = d;
      if (op == OP_CLR || op == OP_WC) model.delete();
    end

    idle();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule